// File: doc/BRIEF.md
# Free-Running Composite Sync Generator

This block produces an active-low composite sync waveform for a television raster using only a fixed 4 MHz clock. No horizontal or vertical reference comes from outside. A line lasts 256 clock cycles (64 µs). Within each line a cycle counter sets the position, and within each frame a line counter sets the line number. From these two counts the block decides, for every half-line, whether to emit a normal line sync pulse, an equalizing pulse or a broad vertical pulse.

Configuration comes from four control inputs:
- A mode input chooses the internal timebase. When it is cleared, an external composite sync input is passed through instead.
- A format input chooses 625 lines (50 Hz) or 525 lines (60 Hz).
- An interlace input chooses two interleaved fields or a repeated first field.
- An enable input forces the output to its inactive level when it is cleared.

The block also outputs the current line number, a field-identity flag and a vertical-interval flag. Downstream raster logic uses them to align with the generated timing.

Top module: `csync_gen`

## Requirements
- R1: While reset is asserted, `csync_n` is 1, `field_id` is 0, `vint` is 0 and `line_no` is 1. The first cycle after reset only captures the configuration, and the outputs hold their reset values during that cycle.
- R2: A line lasts LINE_CYC (256) cycles. Outside the vertical interval, `csync_n` is low for the first W_NORM (19) cycles of each line and high for the rest of the line, including its second half.
- R3: Each half-line in a pre- or post-equalizing run starts with a low pulse of W_EQ (9) cycles.
- R4: Each half-line in a broad run starts with a low pulse of W_BROAD (109) cycles.
- R5: The half-line index is k = 2*(line-1) + (cycle >= 128). The first field's interval consists of pre-equalizing at the last E half-lines of the frame, broad at k = 0..E-1 and post-equalizing at k = E..2E-1. E is 5 for the 50 Hz format (`fmt_50`=1, 625 lines) and 6 for the 60 Hz format (525 lines). `vint` is 1 exactly during these half-lines.
- R6: With `interlace`=1 the frame has N lines (625 or 525). A second interval with the same structure starts N half-lines later (pre-equalizing at k = N-E..N-1, broad at k = N..N+E-1, post-equalizing at k = N+E..N+2E-1). `field_id` is 1 for k >= N.
- R7: With `interlace`=0 a frame has (N+1)/2 lines, only the first-field interval occurs, and `field_id` stays 0.
- R8: When `out_en` is 0, `csync_n` is 1 on the next cycle.
- R9: When the captured mode is 0, `csync_n` equals `ext_csync_n` one cycle later. When the mode is 1, `ext_csync_n` has no effect on `csync_n`.
- R10: `mode_en`, `fmt_50` and `interlace` are captured only at the frame wrap (last cycle of the last line). A change in the middle of a frame leaves that frame's length unchanged.
- R11: `line_no` counts from 1 to the frame length and returns to 1 at the frame wrap. All outputs appear one cycle after the counter state they describe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_en | input | 1 | 1 selects the internal timebase, 0 passes the external sync through |
| fmt_50 | input | 1 | 1 selects 625 lines / 50 Hz, 0 selects 525 lines / 60 Hz |
| interlace | input | 1 | 1 selects two interleaved fields, 0 repeats the first field |
| out_en | input | 1 | 0 holds `csync_n` high |
| ext_csync_n | input | 1 | External composite sync, used only when the mode is 0 |
| csync_n | output | 1 | Composite sync, active low |
| field_id | output | 1 | 1 during the second field of an interlaced frame |
| vint | output | 1 | 1 during equalizing and broad half-lines |
| line_no | output | LW | Current line number, starting at 1 |

## Verification
The frame wrap is the single cycle in which two things happen together. The new configuration is captured, and the first field's broad run begins. The bench changes format and interlace in the middle of a frame and checks two results. First, the measured frame length still belongs to the old setting. Second, the last pre-equalizing pulses follow the old count, while the broad pulses after the wrap follow the new format's count, half-line by half-line. A cycle-accurate scoreboard model judges every output on every cycle, so an off-by-one at either side of the wrap shows up as a mismatch tagged with the affected requirement.

// File: rtl/csync_gen.sv
module csync_gen #(
  parameter int LINE_CYC = 256,
  parameter int L50      = 625,
  parameter int L60      = 525,
  parameter int EQ50     = 5,
  parameter int EQ60     = 6,
  parameter int W_NORM   = 19,
  parameter int W_EQ     = 9,
  parameter int W_BROAD  = 109,
  localparam int LMAX    = (L50 > L60) ? L50 : L60,
  localparam int LW      = $clog2(LMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_en,
  input  logic          fmt_50,
  input  logic          interlace,
  input  logic          out_en,
  input  logic          ext_csync_n,
  output logic          csync_n,
  output logic          field_id,
  output logic          vint,
  output logic [LW-1:0] line_no
);
  localparam int HW   = $clog2(LINE_CYC);
  localparam int KW   = LW + 2;
  localparam int HALF = LINE_CYC / 2;
  localparam logic [KW-1:0] N50 = KW'(L50);
  localparam logic [KW-1:0] N60 = KW'(L60);
  localparam logic [KW-1:0] E50 = KW'(EQ50);
  localparam logic [KW-1:0] E60 = KW'(EQ60);

  logic          pend, c_mode, c_fmt, c_il;
  logic [HW-1:0] hcnt, hpos, wid;
  logic [LW-1:0] lcnt;
  logic [KW-1:0] n_tot, eqn, lim, tot, k;
  logic          half, pre1, br1, po1, pre2, br2, po2, eq, br, low;
  logic          wrap_line, wrap_frame;

  assign n_tot = c_fmt ? N50 : N60;
  assign eqn   = c_fmt ? E50 : E60;
  assign lim   = c_il ? n_tot : ((n_tot + KW'(1)) >> 1);
  assign tot   = lim << 1;

  assign half = hcnt >= HW'(HALF);
  assign hpos = half ? hcnt - HW'(HALF) : hcnt;
  assign k    = ((KW'(lcnt) - KW'(1)) << 1) + KW'(half);

  assign pre1 = k >= tot - eqn;
  assign br1  = k < eqn;
  assign po1  = (k >= eqn) && (k < (eqn << 1));
  assign pre2 = c_il && (k >= n_tot - eqn) && (k < n_tot);
  assign br2  = c_il && (k >= n_tot) && (k < n_tot + eqn);
  assign po2  = c_il && (k >= n_tot + eqn) && (k < n_tot + (eqn << 1));
  assign eq   = pre1 | po1 | pre2 | po2;
  assign br   = br1 | br2;

  assign wid = br ? HW'(W_BROAD) : eq ? HW'(W_EQ) : half ? '0 : HW'(W_NORM);
  assign low = hpos < wid;

  assign wrap_line  = hcnt == HW'(LINE_CYC - 1);
  assign wrap_frame = wrap_line && (KW'(lcnt) == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend     <= 1'b1;
      c_mode   <= 1'b0;
      c_fmt    <= 1'b0;
      c_il     <= 1'b0;
      hcnt     <= '0;
      lcnt     <= LW'(1);
      csync_n  <= 1'b1;
      field_id <= 1'b0;
      vint     <= 1'b0;
      line_no  <= LW'(1);
    end else if (pend) begin
      pend   <= 1'b0;
      c_mode <= mode_en;
      c_fmt  <= fmt_50;
      c_il   <= interlace;
    end else begin
      csync_n  <= !out_en ? 1'b1 : (c_mode ? !low : ext_csync_n);
      field_id <= c_il && (k >= n_tot);
      vint     <= eq | br;
      line_no  <= lcnt;
      if (wrap_line) begin
        hcnt <= '0;
        if (wrap_frame) begin
          lcnt   <= LW'(1);
          c_mode <= mode_en;
          c_fmt  <= fmt_50;
          c_il   <= interlace;
        end else begin
          lcnt <= lcnt + LW'(1);
        end
      end else begin
        hcnt <= hcnt + HW'(1);
      end
    end
  end

  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !pend) |=> csync_n);

  p_ext_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !c_mode && out_en) |=> (csync_n == $past(ext_csync_n)));

  p_prog_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_il && $past(!c_il) && !$past(pend)) |-> !field_id);

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !wrap_frame) |=> $stable({c_mode, c_fmt, c_il}));

  p_line_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (line_no >= LW'(1)) && (KW'(line_no) <= KW'(LMAX)));

  p_line_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && wrap_line && !wrap_frame) |=> (lcnt == $past(lcnt) + LW'(1)));
endmodule

// File: tb/csync_gen_bench.sv
module csync_gen_bench;
  localparam int CLK_P = 10;
  localparam int LC    = 256;
  localparam int NL50  = 25;
  localparam int NL60  = 21;
  localparam int LWB   = $clog2(NL50 + 1);

  logic clk = 0, rst_n = 0;
  logic mode_en = 1, fmt_50 = 1, interlace = 1, out_en = 1, ext_csync_n = 1;
  logic csync_n, field_id, vint;
  logic [LWB-1:0] line_no;

  int total = 0, bad = 0, cyc = 0;

  typedef struct { bit cs; bit fd; bit vi; int ln; string tc; string tf; } exp_t;
  exp_t q[$];

  csync_gen #(.L50(NL50), .L60(NL60)) u_csync_gen (
    .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .fmt_50(fmt_50),
    .interlace(interlace), .out_en(out_en), .ext_csync_n(ext_csync_n),
    .csync_n(csync_n), .field_id(field_id), .vint(vint), .line_no(line_no));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // scoreboard model: pushes one expected item per clock
  bit m_pend, m_mode, m_fmt, m_il, m_cs, m_fd, m_vi;
  int m_h, m_l, m_ln;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend = 1; m_mode = 0; m_fmt = 0; m_il = 0;
      m_h = 0; m_l = 1; m_cs = 1; m_fd = 0; m_vi = 0; m_ln = 1;
    end else begin
      exp_t it;
      it.tc = "R1"; it.tf = "R1";
      if (m_pend) begin
        m_mode = mode_en; m_fmt = fmt_50; m_il = interlace; m_pend = 0;
      end else begin
        int n, e, lim, k, hp, w;
        bit hf, eqf, brf;
        n   = m_fmt ? NL50 : NL60;
        e   = m_fmt ? 5 : 6;
        lim = m_il ? n : (n + 1) / 2;
        hf  = m_h >= LC/2;
        hp  = m_h % (LC/2);
        k   = 2*(m_l - 1) + int'(hf);
        brf = (k < e) || (m_il && k >= n && k < n + e);
        eqf = (k >= 2*lim - e) || (k >= e && k < 2*e) ||
              (m_il && ((k >= n - e && k < n) || (k >= n + e && k < n + 2*e)));
        w   = brf ? 109 : eqf ? 9 : hf ? 0 : 19;
        m_cs = !out_en ? 1'b1 : (m_mode ? !(hp < w) : ext_csync_n);
        it.tc = !out_en ? "R8" : !m_mode ? "R9" : brf ? "R4" : eqf ? "R3" : "R2";
        it.tf = m_il ? "R6" : "R7";
        m_fd = m_il && k >= n;
        m_vi = brf || eqf;
        m_ln = m_l;
        if (m_h == LC - 1) begin
          m_h = 0;
          if (m_l == lim) begin
            m_l = 1; m_mode = mode_en; m_fmt = fmt_50; m_il = interlace;
          end else m_l++;
        end else m_h++;
      end
      it.cs = m_cs; it.fd = m_fd; it.vi = m_vi; it.ln = m_ln;
      q.push_back(it);
    end
  end

  // monitor: compares away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      chk(it.tc, int'(csync_n), int'(it.cs));
      chk(it.tf, int'(field_id), int'(it.fd));
      chk("R5", int'(vint), int'(it.vi));
      chk("R11", int'(line_no), it.ln);
    end
  end

  task automatic wait_fs();
    int p;
    p = int'(line_no);
    forever begin
      @(negedge clk);
      if (int'(line_no) == 1 && p != 1) break;
      p = int'(line_no);
    end
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      ext_csync_n = cyc[3] ^ cyc[6];
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(csync_n), 1);
    chk("R1", int'(field_id), 0);
    chk("R1", int'(vint), 0);
    chk("R1", int'(line_no), 1);
    rst_n = 1;
    run(2 * NL50 * LC + 100);
    // R10: mid-frame format change must not alter current frame length
    begin
      int t0;
      wait_fs();
      t0 = cyc;
      run(1000);
      fmt_50 = 0;
      wait_fs();
      chk("R10", cyc - t0, NL50 * LC);
    end
    run(2 * NL60 * LC);
    interlace = 0;
    run(3 * ((NL60 + 1) / 2) * LC + 50);
    fmt_50 = 1;
    run(3 * ((NL50 + 1) / 2) * LC);
    out_en = 0;
    run(400);
    out_en = 1;
    mode_en = 0;
    run(2 * ((NL50 + 1) / 2) * LC);
    mode_en = 1; interlace = 1; fmt_50 = 0;
    run(2 * NL60 * LC + 2 * NL50 * LC);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule